// File: doc/BRIEF.md
# Timing-Stream Receiver with Throttle-State Extraction

This block takes a serial timing stream that uses biphase-mark coding and recovers the two bit channels carried in each bunch period. The first channel carries triggers. The second carries serial frames. The receiver works out which of the two interleaved bit slots holds triggers and which holds frames. Each trigger bit becomes a one-cycle pulse. The frame channel is parsed for short broadcast frames, and each frame is checked by its stop bit, its format bit and a five-bit Hamming field.

The upper nibble of every accepted broadcast command is kept as the current 4-bit throttle state. A local trigger generator and the legacy outputs read that state. Command 0x01 marks the start of an orbit. The trigger pulses and orbit pulses are also widened into fixed-length auxiliary pulses that can drive slow outputs.

The sampling clock runs at four times the bunch rate, which gives two samples per bit cell. An upstream recovery stage asserts `cell_stb` on the first-half sample of each cell. Analog clock and data recovery is not part of this block. Hamming errors are flagged but not corrected.

Top module: `ttc_rx_tts`

## Requirements
- R1: Each bit cell is two samples long, and `cell_stb` marks the first. The line level changes at every cell boundary. A cell decodes as 1 when its two halves differ and as 0 when they are equal.
- R2: If a cell's first half equals the previous cell's second half (a missing boundary transition), `line_err_o` pulses one cycle after the cell's second-half sample. That cell yields no bit, and frame search restarts.
- R3: Decoded bits alternate between the trigger slot and the frame slot. A trigger-slot bit of 1 produces a single-cycle `trig_o` pulse two cycles after its second-half sample.
- R4: When the trigger slot holds 1 for an eleventh consecutive time, `ab_phase_o` toggles and the slot roles swap. That bit produces no trigger, the run count clears, and frame search restarts.
- R5: The frame slot idles at 1. A 0 is the start bit. It is followed by 15 bits, sent first to last: a format bit (0 for broadcast), command bits 7 down to 0, check bits h4 down to h0, and a stop bit (1). The check bits are: h0 = d0^d1^d2^d3, h1 = d0^d4^d5^d6, h2 = d1^d2^d4^d5^d7, h3 = d1^d3^d4^d6^d7, and h4 = XOR of all eight data bits and h0..h3.
- R6: A valid frame pulses `cmd_vld_o`, places the command on `cmd_o`, and sets `tts_o` to its upper nibble. All three take effect two cycles after the stop bit's second-half sample.
- R7: A frame with a wrong stop bit, format bit 1, or a check-bit mismatch pulses `frame_err_o` in that same cycle. `cmd_vld_o` does not pulse, and `tts_o` and `cmd_o` keep their values.
- R8: A valid command equal to 0x01 also pulses `bcr_o` together with `cmd_vld_o`.
- R9: After reset, `tts_o` is 0x0 (not Ready), `cmd_o` is 0, `ab_phase_o` is 0, and every pulse and auxiliary output is low.
- R10: `aux_trig_o` and `aux_orbit_o` go high in the cycle of their source pulse (`trig_o` or `bcr_o`) and stay high for AUX_CYC cycles (12 by default). A new source pulse restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, four times the bunch rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Sampled serial line |
| cell_stb | input | 1 | High on the first-half sample of each bit cell |
| trig_o | output | 1 | Trigger pulse |
| bcr_o | output | 1 | Orbit-start command pulse |
| cmd_vld_o | output | 1 | Valid broadcast command pulse |
| cmd_o | output | 8 | Last valid command |
| tts_o | output | 4 | Current throttle state |
| frame_err_o | output | 1 | Rejected frame pulse |
| line_err_o | output | 1 | Missing boundary transition pulse |
| ab_phase_o | output | 1 | Current slot assignment |
| aux_trig_o | output | 1 | Widened trigger pulse |
| aux_orbit_o | output | 1 | Widened orbit pulse |

## Verification
The properties assume that `cell_stb` is high on every other cycle, and that a real trigger stream never holds the trigger slot at 1 for eleven cells in a row. The bench drives whole cells through a task, so the strobe always alternates. It never sends more than five triggers back to back. It starts the stream one bit out of step, and later drops one cell, so that a realignment happens both times through the idle 1s in the frame slot and never through triggers.

// File: rtl/ttcr_pkg.sv
package ttcr_pkg;

    localparam int CMD_W   = 8;
    localparam int CHK_W   = 5;
    localparam int TTS_W   = 4;
    localparam int FRM_LEN = 1 + CMD_W + CHK_W + 1;  // format, data, check, stop

    // check bits {h4, h3, h2, h1, h0} over command d
    function automatic logic [CHK_W-1:0] ttcr_ham(input logic [CMD_W-1:0] d);
        logic [3:0] h;
        h[0] = d[0] ^ d[1] ^ d[2] ^ d[3];
        h[1] = d[0] ^ d[4] ^ d[5] ^ d[6];
        h[2] = d[1] ^ d[2] ^ d[4] ^ d[5] ^ d[7];
        h[3] = d[1] ^ d[3] ^ d[4] ^ d[6] ^ d[7];
        return {(^d) ^ (^h), h};
    endfunction

endpackage

// File: rtl/ttcr_bmc_dec.sv
module ttcr_bmc_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic cell_stb,
    output logic bit_vld,
    output logic bit_val,
    output logic line_err
);
    typedef struct packed {
        logic s0;        // first-half sample
        logic prev;      // second half of the last cell
        logic has_prev;
        logic in_cell;   // next sample is a second half
        logic vld;
        logic val;
        logic err;
    } dec_t;

    dec_t st_q, st_d;

    always_comb begin
        st_d         = st_q;
        st_d.vld     = 1'b0;
        st_d.err     = 1'b0;
        st_d.in_cell = 1'b0;
        if (cell_stb) begin
            st_d.s0      = line_in;
            st_d.in_cell = 1'b1;
        end else if (st_q.in_cell) begin
            if (st_q.has_prev && (st_q.s0 == st_q.prev)) begin
                st_d.err = 1'b1;
            end else begin
                st_d.vld = 1'b1;
                st_d.val = st_q.s0 ^ line_in;
            end
            st_d.prev     = line_in;
            st_d.has_prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_vld  = st_q.vld;
    assign bit_val  = st_q.val;
    assign line_err = st_q.err;
endmodule

// File: rtl/ttcr_chan_split.sv
module ttcr_chan_split #(
    parameter int RUN_MAX = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_val,
    output logic trig_now,
    output logic trig_q,
    output logic phase_q,
    output logic swap,
    output logic b_vld,
    output logic b_val
);
    localparam int RW = $clog2(RUN_MAX + 1);

    typedef struct packed {
        logic          slot;
        logic          phase;
        logic [RW-1:0] run;
        logic          trig;
    } spl_t;

    spl_t st_q, st_d;
    logic is_a;

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        trig_now  = 1'b0;
        swap      = 1'b0;
        is_a      = (st_q.slot == st_q.phase);
        if (bit_vld) begin
            st_d.slot = ~st_q.slot;
            if (is_a) begin
                if (!bit_val) begin
                    st_d.run = '0;
                end else if (st_q.run == RW'(RUN_MAX)) begin
                    st_d.run   = '0;
                    st_d.phase = ~st_q.phase;
                    swap       = 1'b1;
                end else begin
                    st_d.run  = st_q.run + RW'(1);
                    st_d.trig = 1'b1;
                    trig_now  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign b_vld   = bit_vld & ~is_a;
    assign b_val   = bit_val;
    assign trig_q  = st_q.trig;
    assign phase_q = st_q.phase;
endmodule

// File: rtl/ttcr_bcast_rx.sv
module ttcr_bcast_rx
    import ttcr_pkg::*;
#(
    parameter logic [TTS_W-1:0] TTS_RST  = 4'h0,
    parameter logic [CMD_W-1:0] BCR_CODE = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             b_vld,
    input  logic             b_val,
    output logic             evt_bcr,
    output logic             cmd_vld,
    output logic [CMD_W-1:0] cmd,
    output logic [TTS_W-1:0] tts,
    output logic             bcr,
    output logic             ferr
);
    localparam int CW = $clog2(FRM_LEN);

    typedef struct packed {
        logic               busy;
        logic [CW-1:0]      cnt;
        logic [FRM_LEN-2:0] sh;
        logic               vld;
        logic [CMD_W-1:0]   cmd;
        logic [TTS_W-1:0]   tts;
        logic               bcr;
        logic               err;
    } frm_t;

    frm_t               st_q, st_d;
    logic [FRM_LEN-1:0] vec;
    logic               good;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.bcr = 1'b0;
        st_d.err = 1'b0;
        evt_bcr  = 1'b0;
        vec      = {st_q.sh, b_val};
        good     = (vec[FRM_LEN-1] == 1'b0) && vec[0]
                   && (vec[CHK_W:1] == ttcr_ham(vec[FRM_LEN-2 -: CMD_W]));
        if (restart) begin
            st_d.busy = 1'b0;
        end else if (b_vld) begin
            if (!st_q.busy) begin
                if (!b_val) begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                end
            end else if (st_q.cnt == CW'(FRM_LEN - 1)) begin
                st_d.busy = 1'b0;
                if (good) begin
                    st_d.vld = 1'b1;
                    st_d.cmd = vec[FRM_LEN-2 -: CMD_W];
                    st_d.tts = vec[FRM_LEN-2 -: TTS_W];
                    st_d.bcr = (vec[FRM_LEN-2 -: CMD_W] == BCR_CODE);
                    evt_bcr  = st_d.bcr;
                end else begin
                    st_d.err = 1'b1;
                end
            end else begin
                st_d.sh  = vec[FRM_LEN-2:0];
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.tts <= TTS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_vld = st_q.vld;
    assign cmd     = st_q.cmd;
    assign tts     = st_q.tts;
    assign bcr     = st_q.bcr;
    assign ferr    = st_q.err;
endmodule

// File: rtl/ttc_rx_tts.sv
module ttc_rx_tts
    import ttcr_pkg::*;
#(
    parameter int               AUX_CYC = 12,
    parameter int               RUN_MAX = 10,
    parameter logic [TTS_W-1:0] TTS_RST = 4'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             cell_stb,
    output logic             trig_o,
    output logic             bcr_o,
    output logic             cmd_vld_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic [TTS_W-1:0] tts_o,
    output logic             frame_err_o,
    output logic             line_err_o,
    output logic             ab_phase_o,
    output logic             aux_trig_o,
    output logic             aux_orbit_o
);
    localparam int AW   = $clog2(AUX_CYC + 1);
    localparam int NAUX = 2;

    logic bit_vld, bit_val, trig_now, swap, b_vld, b_val, evt_bcr;

    ttcr_bmc_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .cell_stb (cell_stb),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .line_err (line_err_o)
    );

    ttcr_chan_split #(.RUN_MAX(RUN_MAX)) u_split (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .trig_now (trig_now),
        .trig_q   (trig_o),
        .phase_q  (ab_phase_o),
        .swap     (swap),
        .b_vld    (b_vld),
        .b_val    (b_val)
    );

    ttcr_bcast_rx #(.TTS_RST(TTS_RST)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (line_err_o | swap),
        .b_vld    (b_vld),
        .b_val    (b_val),
        .evt_bcr  (evt_bcr),
        .cmd_vld  (cmd_vld_o),
        .cmd      (cmd_o),
        .tts      (tts_o),
        .bcr      (bcr_o),
        .ferr     (frame_err_o)
    );

    // pulse wideners for the auxiliary outputs
    typedef struct packed {
        logic [NAUX-1:0][AW-1:0] cnt;
    } aux_t;

    aux_t            aux_q, aux_d;
    logic [NAUX-1:0] load;
    logic [NAUX-1:0] aux_on;

    assign load = {evt_bcr, trig_now};

    always_comb begin
        aux_d = aux_q;
        for (int i = 0; i < NAUX; i++) begin
            if (load[i])                aux_d.cnt[i] = AW'(AUX_CYC);
            else if (aux_q.cnt[i] != 0) aux_d.cnt[i] = aux_q.cnt[i] - AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) aux_q <= '0;
        else        aux_q <= aux_d;
    end

    for (genvar gi = 0; gi < NAUX; gi++) begin : g_aux
        assign aux_on[gi] = (aux_q.cnt[gi] != '0);
    end

    assign aux_trig_o  = aux_on[0];
    assign aux_orbit_o = aux_on[1];
endmodule

// File: rtl/ttc_rx_tts_chk.sv
module ttc_rx_tts_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_o,
    input logic       bcr_o,
    input logic       cmd_vld_o,
    input logic [7:0] cmd_o,
    input logic [3:0] tts_o,
    input logic       frame_err_o,
    input logic       line_err_o,
    input logic       ab_phase_o,
    input logic       aux_trig_o,
    input logic       aux_orbit_o
);
    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);                                        // R3
    AST_LINE_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        line_err_o |=> !trig_o);                                    // R2
    AST_SWAP_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ab_phase_o) |-> !trig_o);                          // R4
    AST_TTS_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> (tts_o == cmd_o[7:4]));                       // R6
    AST_TTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld_o |-> $stable(tts_o));                             // R7
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err_o && cmd_vld_o));                               // R7
    AST_BCR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        bcr_o |-> (cmd_vld_o && cmd_o == 8'h01));                   // R8
    AST_AUX_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> aux_trig_o);                                     // R10
    AST_AUX_ORBIT: assert property (@(posedge clk) disable iff (!rst_n)
        bcr_o |-> aux_orbit_o);                                     // R10
endmodule

bind ttc_rx_tts ttc_rx_tts_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_o      (trig_o),
    .bcr_o       (bcr_o),
    .cmd_vld_o   (cmd_vld_o),
    .cmd_o       (cmd_o),
    .tts_o       (tts_o),
    .frame_err_o (frame_err_o),
    .line_err_o  (line_err_o),
    .ab_phase_o  (ab_phase_o),
    .aux_trig_o  (aux_trig_o),
    .aux_orbit_o (aux_orbit_o)
);

// File: tb/ttc_rx_tts_bench.sv
`timescale 1ns/1ps
module ttc_rx_tts_bench;
    localparam int AUX = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       cell_stb = 1'b0;
    logic       trig_o, bcr_o, cmd_vld_o, frame_err_o, line_err_o, ab_phase_o;
    logic       aux_trig_o, aux_orbit_o;
    logic [7:0] cmd_o;
    logic [3:0] tts_o;

    always #4 clk = ~clk;

    ttc_rx_tts u_ttc_rx_tts (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .cell_stb(cell_stb),
        .trig_o(trig_o), .bcr_o(bcr_o), .cmd_vld_o(cmd_vld_o), .cmd_o(cmd_o),
        .tts_o(tts_o), .frame_err_o(frame_err_o), .line_err_o(line_err_o),
        .ab_phase_o(ab_phase_o), .aux_trig_o(aux_trig_o), .aux_orbit_o(aux_orbit_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 0;

    // expected events keyed by cycle number
    bit e_trig[int], e_line[int], e_cmdv[int], e_ferr[int], e_bcr[int];
    bit e_auxt[int], e_auxo[int];
    int e_tts_set[int], e_cmd_set[int], e_ph_set[int];
    int x_tts = 0, x_cmd = 0, x_ph = 0;

    // behavioural protocol model
    int         m_slot = 0, m_phase = 0, m_run = 0, m_busy = 0, m_cnt = 0;
    logic [14:0] m_vec;
    logic       lvl = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [4:0] hb(input logic [7:0] d);
        logic h0, h1, h2, h3;
        h0 = ^(d & 8'b0000_1111);
        h1 = ^(d & 8'b0111_0001);
        h2 = ^(d & 8'b1011_0110);
        h3 = ^(d & 8'b1101_1010);
        return {^{d, h0, h1, h2, h3}, h3, h2, h1, h0};
    endfunction

    task automatic model(input bit b, input bit bad, input int p);
        bit is_a;
        if (bad) begin
            e_line[p+1] = 1;
            m_busy = 0;
            return;
        end
        is_a = (m_slot == m_phase);
        m_slot ^= 1;
        if (is_a) begin
            if (!b) m_run = 0;
            else if (m_run == 10) begin
                m_run = 0; m_phase ^= 1; m_busy = 0;
                e_ph_set[p+2] = m_phase;
            end else begin
                m_run++;
                e_trig[p+2] = 1;
                for (int k = 0; k < AUX; k++) e_auxt[p+2+k] = 1;
            end
        end else if (!m_busy) begin
            if (!b) begin m_busy = 1; m_cnt = 0; end
        end else begin
            m_vec = {m_vec[13:0], b};
            m_cnt++;
            if (m_cnt == 15) begin
                m_busy = 0;
                if (m_vec[14] == 0 && m_vec[0] == 1 && m_vec[5:1] == hb(m_vec[13:6])) begin
                    e_cmdv[p+2] = 1;
                    e_cmd_set[p+2] = m_vec[13:6];
                    e_tts_set[p+2] = m_vec[13:10];
                    if (m_vec[13:6] == 8'h01) begin
                        e_bcr[p+2] = 1;
                        for (int k = 0; k < AUX; k++) e_auxo[p+2+k] = 1;
                    end
                end else e_ferr[p+2] = 1;
            end
        end
    endtask

    task automatic send_cell(input bit b, input bit bad);
        int p;
        @(negedge clk);
        p = cyc + 1;
        if (!bad) lvl = ~lvl;
        line_in = lvl; cell_stb = 1'b1;
        @(negedge clk);
        if (b) lvl = ~lvl;
        line_in = lvl; cell_stb = 1'b0;
        model(b, bad, p);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin send_cell(0, 0); send_cell(1, 0); end
    endtask

    task automatic send_frame(input logic [7:0] c, input bit fmt, input bit stopb,
                              input logic [4:0] hflip, input logic [15:0] trig, input int bad_at);
        logic [15:0] fr;
        fr = {1'b0, fmt, c, hb(c) ^ hflip, stopb};
        for (int i = 15; i >= 0; i--) begin
            send_cell(trig[i], 0);
            send_cell(fr[i], bad_at == i);
        end
        idle(2);
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            if (e_tts_set.exists(cyc)) x_tts = e_tts_set[cyc];
            if (e_cmd_set.exists(cyc)) x_cmd = e_cmd_set[cyc];
            if (e_ph_set.exists(cyc))  x_ph  = e_ph_set[cyc];
            chk("R3 trig_o (R1 decode)", trig_o, e_trig.exists(cyc));
            chk("R2 line_err_o", line_err_o, e_line.exists(cyc));
            chk("R6 cmd_vld_o (R5 frame)", cmd_vld_o, e_cmdv.exists(cyc));
            chk("R7 frame_err_o", frame_err_o, e_ferr.exists(cyc));
            chk("R8 bcr_o", bcr_o, e_bcr.exists(cyc));
            chk("R6 tts_o (R7 hold)", tts_o, x_tts);
            chk("R6 cmd_o", cmd_o, x_cmd);
            chk("R4 ab_phase_o", ab_phase_o, x_ph);
            chk("R10 aux_trig_o", aux_trig_o, e_auxt.exists(cyc));
            chk("R10 aux_orbit_o", aux_orbit_o, e_auxo.exists(cyc));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 tts_o", tts_o, 0);
        chk("R9 cmd_o", cmd_o, 0);
        chk("R9 ab_phase_o", ab_phase_o, 0);
        chk("R9 pulses", {trig_o, bcr_o, cmd_vld_o, frame_err_o, line_err_o}, 0);
        chk("R9 aux", {aux_trig_o, aux_orbit_o}, 0);
        cmp_on = 1;
        // one stray bit puts the stream out of step, idle 1s force a swap
        send_cell(1, 0);
        idle(14);
        send_frame(8'h85, 0, 1, 5'h00, 16'h2000, -1);
        send_frame(8'h01, 0, 1, 5'h00, 16'h07C0, -1);
        send_frame(8'h3C, 0, 0, 5'h00, 16'h0000, -1);
        send_frame(8'h42, 0, 1, 5'h04, 16'h0000, -1);
        send_frame(8'h9A, 1, 1, 5'h00, 16'h0000, -1);
        send_frame(8'h27, 0, 1, 5'h00, 16'h0000, 6);
        idle(14);
        send_frame(8'h10, 0, 1, 5'h00, 16'h0101, -1);
        send_frame(8'h01, 0, 1, 5'h00, 16'h0000, -1);
        send_frame(8'hF0, 0, 1, 5'h00, 16'h0000, -1);
        idle(6);
        repeat (AUX + 4) @(negedge clk);
        cmp_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule